// File: doc/BRIEF.md
# USB Host Pipe Control State

This block keeps the control state of a single host-side USB pipe. Five interrupt-enable bits, a bank-ownership flag, a request-freeze bit and a toggle-reset bit are held here. Software changes each bit with its own one-cycle set and clear strobes. A protocol engine sends one-cycle event pulses and a few levels that set or clear some of the bits in hardware.

The bank-ownership flag changes meaning with the pipe direction. On an OUT or SETUP pipe, hardware raises it when a bank becomes free. On an IN pipe, hardware raises it when received data has been stored. In both cases a software clear hands the bank back and emits a one-cycle bank-switch pulse.

Request generation is frozen automatically in these cases:
- the pipe is not configured;
- a STALL is received;
- the pipe error flag is high;
- the pipe is reset or enabled;
- a programmed limit plus one completed IN requests have been counted.

A toggle-reset request returns the data toggle to DATA0. There are no data streams here, so every pin is a plain control or status signal.

Top module: `pipe_ctl`

## Requirements
- R1: Interrupt-enable bit i (0 overflow, 1 STALL received, 2 CRC error, 3 short packet, 4 busy-bank count) is 1 in the cycle after `ien_set[i]` and 0 in the cycle after `ien_clr[i]`. When both strobes are high together, set wins.
- R2: An interrupt-enable strobe changes only its own bit. A clear strobe on a bit that is already 0 leaves it at 0.
- R3: When `pipe_dir` is OUT (2'b00) or SETUP (2'b10), `ev_bank_free` sets `fifo_con` in the next cycle and `ev_in_stored` has no effect on it.
- R4: When `pipe_dir` is IN (2'b01), `ev_in_stored` sets `fifo_con` in the next cycle and `ev_bank_free` has no effect on it.
- R5: `fifo_clr` while `fifo_con` is 1 clears `fifo_con` in the next cycle. In that same cycle `bank_sw` is high for exactly one cycle. `fifo_clr` while `fifo_con` is 0 gives no pulse.
- R6: A hardware set of `fifo_con` in the same cycle as `fifo_clr` keeps `fifo_con` at 1 and gives no `bank_sw` pulse.
- R7: `freeze` is 1 out of reset. It is 1 in the cycle after any of these: `cfg_ok` low, `ev_stall`, `ev_err` high, `ev_pipe_rst`, `ev_pipe_en`, or `frz_set`. Otherwise `frz_clr` clears it in the next cycle.
- R8: While `freeze` is 0, each `ev_in_done` is counted. The completion that arrives when the count equals `in_limit` (the `in_limit`+1-th) sets `freeze`. Completions that arrive while frozen are not counted. The count restarts at zero when software clears `freeze`.
- R9: `rtog_set` makes `rtog` and `tog_rst` high for exactly one cycle, starting in the next cycle. Unless `rtog_set` repeats, both return to 0 in the cycle after that, and in that same cycle `data_tog` is 0 (DATA0).
- R10: `data_tog` is 0 out of reset. It inverts in the cycle after each `ev_xfer_ok` unless a toggle reset is being applied in that cycle.
- R11: A hardware freeze condition in the same cycle as `frz_clr` leaves `freeze` at 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| pipe_dir | input | 2 | Pipe direction: 00 OUT, 01 IN, 10 SETUP |
| cfg_ok | input | 1 | Pipe is configured (level) |
| in_limit | input | 8 | Programmed IN-request limit |
| ien_set | input | 5 | Per-bit interrupt-enable set strobes |
| ien_clr | input | 5 | Per-bit interrupt-enable clear strobes |
| frz_set | input | 1 | Software freeze set strobe |
| frz_clr | input | 1 | Software freeze clear strobe |
| fifo_clr | input | 1 | Software bank-ownership clear strobe |
| rtog_set | input | 1 | Software toggle-reset request strobe |
| ev_bank_free | input | 1 | Engine: current bank became free |
| ev_in_stored | input | 1 | Engine: new IN data stored in bank |
| ev_stall | input | 1 | Engine: STALL handshake received |
| ev_err | input | 1 | Engine: pipe error flag (level) |
| ev_in_done | input | 1 | Engine: IN request completed |
| ev_xfer_ok | input | 1 | Engine: transaction completed successfully |
| ev_pipe_rst | input | 1 | Engine: pipe reset |
| ev_pipe_en | input | 1 | Engine: pipe enable |
| ien | output | 5 | Interrupt-enable bits |
| fifo_con | output | 1 | Bank-ownership flag |
| freeze | output | 1 | Request generation frozen |
| rtog | output | 1 | Toggle-reset bit |
| tog_rst | output | 1 | Toggle-reset pulse |
| bank_sw | output | 1 | One-cycle bank-switch pulse |
| data_tog | output | 1 | Current data toggle (0 = DATA0) |

## Verification
Every bit and pulse is registered once. A strobe or event given in cycle t therefore shows its effect in cycle t+1. The exception is `data_tog` after a toggle reset: it reaches 0 one cycle after `tog_rst`, which is t+2 from `rtog_set`. The bench applies stimulus just after a falling edge. For each cycle it queues the output values that the requirements predict for the next cycle, and it compares them shortly after the following rising edge. This way every delay, including the two-cycle toggle path and the one-cycle width of each pulse, is checked exactly where it is due.

// File: rtl/pipe_ctl_pkg.sv
package pipe_ctl_pkg;
  typedef enum logic [1:0] {
    DIR_OUT   = 2'b00,
    DIR_IN    = 2'b01,
    DIR_SETUP = 2'b10
  } pipe_dir_e;

  localparam int unsigned IEN_OVF   = 0;
  localparam int unsigned IEN_STALL = 1;
  localparam int unsigned IEN_CRC   = 2;
  localparam int unsigned IEN_SHORT = 3;
  localparam int unsigned IEN_BUSY  = 4;
  localparam int unsigned IEN_COUNT = 5;
endpackage

// File: rtl/pipe_ien_bank.sv
module pipe_ien_bank #(
  parameter int unsigned N = 5
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [N-1:0] set_i,
  input  logic [N-1:0] clr_i,
  output logic [N-1:0] bits_o
);
  for (genvar g = 0; g < N; g++) begin : g_bit
    logic q;
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)        q <= 1'b0;
      else if (set_i[g]) q <= 1'b1;
      else if (clr_i[g]) q <= 1'b0;
    end
    assign bits_o[g] = q;
  end
endmodule

// File: rtl/pipe_fifo_ctl.sv
module pipe_fifo_ctl
  import pipe_ctl_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic [1:0] dir_i,
  input  logic       bank_free_i,
  input  logic       in_stored_i,
  input  logic       sw_clr_i,
  output logic       fifo_con_o,
  output logic       bank_sw_o
);
  logic con_q, sw_q, hw_set, do_switch;

  assign hw_set    = (dir_i == DIR_IN) ? in_stored_i : bank_free_i;
  assign do_switch = sw_clr_i & con_q & ~hw_set;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      con_q <= 1'b0;
      sw_q  <= 1'b0;
    end else begin
      sw_q <= do_switch;
      if (hw_set)         con_q <= 1'b1;
      else if (do_switch) con_q <= 1'b0;
    end
  end

  assign fifo_con_o = con_q;
  assign bank_sw_o  = sw_q;
endmodule

// File: rtl/pipe_freeze_ctl.sv
module pipe_freeze_ctl #(
  parameter int unsigned CNT_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cfg_ok_i,
  input  logic [CNT_W-1:0] limit_i,
  input  logic             stall_i,
  input  logic             err_i,
  input  logic             in_done_i,
  input  logic             pipe_rst_i,
  input  logic             pipe_en_i,
  input  logic             sw_set_i,
  input  logic             sw_clr_i,
  output logic             freeze_o
);
  logic             frz_q;
  logic [CNT_W-1:0] cnt_q;
  logic             limit_hit, hw_frz, frz_d, sw_unfreeze, count_en;

  assign count_en    = in_done_i & ~frz_q;
  assign limit_hit   = count_en & (cnt_q == limit_i);
  assign hw_frz      = ~cfg_ok_i | stall_i | err_i | pipe_rst_i | pipe_en_i | limit_hit;
  assign frz_d       = hw_frz | sw_set_i | (frz_q & ~sw_clr_i);
  assign sw_unfreeze = sw_clr_i & ~frz_d;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      frz_q <= 1'b1;
      cnt_q <= '0;
    end else begin
      frz_q <= frz_d;
      if (pipe_rst_i || sw_unfreeze) cnt_q <= '0;
      else if (count_en)             cnt_q <= cnt_q + 1'b1;
    end
  end

  assign freeze_o = frz_q;
endmodule

// File: rtl/pipe_toggle_ctl.sv
module pipe_toggle_ctl (
  input  logic clk,
  input  logic rst_n,
  input  logic rtog_set_i,
  input  logic xfer_ok_i,
  output logic rtog_o,
  output logic data_tog_o
);
  logic rtog_q, tog_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rtog_q <= 1'b0;
      tog_q  <= 1'b0;
    end else begin
      rtog_q <= rtog_set_i;
      if (rtog_q)         tog_q <= 1'b0;
      else if (xfer_ok_i) tog_q <= ~tog_q;
    end
  end

  assign rtog_o     = rtog_q;
  assign data_tog_o = tog_q;
endmodule

// File: rtl/pipe_ctl.sv
module pipe_ctl #(
  parameter int unsigned NUM_IEN = 5,
  parameter int unsigned CNT_W   = 8
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [1:0]         pipe_dir,
  input  logic               cfg_ok,
  input  logic [CNT_W-1:0]   in_limit,
  input  logic [NUM_IEN-1:0] ien_set,
  input  logic [NUM_IEN-1:0] ien_clr,
  input  logic               frz_set,
  input  logic               frz_clr,
  input  logic               fifo_clr,
  input  logic               rtog_set,
  input  logic               ev_bank_free,
  input  logic               ev_in_stored,
  input  logic               ev_stall,
  input  logic               ev_err,
  input  logic               ev_in_done,
  input  logic               ev_xfer_ok,
  input  logic               ev_pipe_rst,
  input  logic               ev_pipe_en,
  output logic [NUM_IEN-1:0] ien,
  output logic               fifo_con,
  output logic               freeze,
  output logic               rtog,
  output logic               tog_rst,
  output logic               bank_sw,
  output logic               data_tog
);
  logic rtog_w;

  pipe_ien_bank #(.N(NUM_IEN)) u_ien (
    .clk(clk), .rst_n(rst_n), .set_i(ien_set), .clr_i(ien_clr), .bits_o(ien)
  );

  pipe_fifo_ctl u_fifo (
    .clk(clk), .rst_n(rst_n), .dir_i(pipe_dir),
    .bank_free_i(ev_bank_free), .in_stored_i(ev_in_stored),
    .sw_clr_i(fifo_clr), .fifo_con_o(fifo_con), .bank_sw_o(bank_sw)
  );

  pipe_freeze_ctl #(.CNT_W(CNT_W)) u_frz (
    .clk(clk), .rst_n(rst_n), .cfg_ok_i(cfg_ok), .limit_i(in_limit),
    .stall_i(ev_stall), .err_i(ev_err), .in_done_i(ev_in_done),
    .pipe_rst_i(ev_pipe_rst), .pipe_en_i(ev_pipe_en),
    .sw_set_i(frz_set), .sw_clr_i(frz_clr), .freeze_o(freeze)
  );

  pipe_toggle_ctl u_tog (
    .clk(clk), .rst_n(rst_n), .rtog_set_i(rtog_set), .xfer_ok_i(ev_xfer_ok),
    .rtog_o(rtog_w), .data_tog_o(data_tog)
  );

  assign rtog    = rtog_w;
  assign tog_rst = rtog_w;
endmodule

// File: rtl/pipe_ctl_chk.sv
module pipe_ctl_chk #(
  parameter int unsigned NUM_IEN = 5,
  parameter int unsigned CNT_W   = 8
) (
  input logic               clk,
  input logic               rst_n,
  input logic [1:0]         pipe_dir,
  input logic               cfg_ok,
  input logic [NUM_IEN-1:0] ien_set,
  input logic [NUM_IEN-1:0] ien_clr,
  input logic               frz_set,
  input logic               frz_clr,
  input logic               fifo_clr,
  input logic               rtog_set,
  input logic               ev_bank_free,
  input logic               ev_stall,
  input logic               ev_pipe_en,
  input logic               ev_xfer_ok,
  input logic [NUM_IEN-1:0] ien,
  input logic               fifo_con,
  input logic               freeze,
  input logic               tog_rst,
  input logic               bank_sw,
  input logic               data_tog
);
  a_r1_set_wins: assert property (@(posedge clk) disable iff (!rst_n)
    ien_set[0] |=> ien[0]);

  a_r3_bank_free_sets: assert property (@(posedge clk) disable iff (!rst_n)
    (ev_bank_free && pipe_dir != 2'b01) |=> fifo_con);

  a_r5_switch_cause: assert property (@(posedge clk) disable iff (!rst_n)
    bank_sw |-> ($past(fifo_clr) && $past(fifo_con)));

  a_r6_switch_clears: assert property (@(posedge clk) disable iff (!rst_n)
    bank_sw |-> !fifo_con);

  a_r7_stall_freezes: assert property (@(posedge clk) disable iff (!rst_n)
    ev_stall |=> freeze);

  a_r7_enable_freezes: assert property (@(posedge clk) disable iff (!rst_n)
    ev_pipe_en |=> freeze);

  a_r9_pulse_cause: assert property (@(posedge clk) disable iff (!rst_n)
    tog_rst |-> $past(rtog_set));

  a_r9_data0_after: assert property (@(posedge clk) disable iff (!rst_n)
    tog_rst |=> !data_tog);

  a_r10_flip: assert property (@(posedge clk) disable iff (!rst_n)
    (ev_xfer_ok && !tog_rst) |=> (data_tog != $past(data_tog)));

  a_r11_hw_beats_clear: assert property (@(posedge clk) disable iff (!rst_n)
    (frz_clr && !cfg_ok) |=> freeze);
endmodule

bind pipe_ctl pipe_ctl_chk #(.NUM_IEN(NUM_IEN), .CNT_W(CNT_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .pipe_dir(pipe_dir), .cfg_ok(cfg_ok),
  .ien_set(ien_set), .ien_clr(ien_clr), .frz_set(frz_set), .frz_clr(frz_clr),
  .fifo_clr(fifo_clr), .rtog_set(rtog_set), .ev_bank_free(ev_bank_free),
  .ev_stall(ev_stall), .ev_pipe_en(ev_pipe_en), .ev_xfer_ok(ev_xfer_ok),
  .ien(ien), .fifo_con(fifo_con), .freeze(freeze), .tog_rst(tog_rst),
  .bank_sw(bank_sw), .data_tog(data_tog)
);

// File: tb/pipe_ctl_bench.sv
module pipe_ctl_bench;
  localparam int CLK_PERIOD = 10;

  typedef struct {
    logic [4:0] ien;
    logic       fc;
    logic       frz;
    logic       rt;
    logic       bsw;
    logic       tog;
    string      tag;
  } exp_t;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [1:0] pipe_dir = 2'b00;
  logic cfg_ok = 1'b1;
  logic [7:0] in_limit = 8'd2;
  logic [4:0] ien_set = '0, ien_clr = '0;
  logic frz_set = 0, frz_clr = 0, fifo_clr = 0, rtog_set = 0;
  logic ev_bank_free = 0, ev_in_stored = 0, ev_stall = 0, ev_err = 0;
  logic ev_in_done = 0, ev_xfer_ok = 0, ev_pipe_rst = 0, ev_pipe_en = 0;
  logic [4:0] ien;
  logic fifo_con, freeze, rtog, tog_rst, bank_sw, data_tog;

  int checks = 0;
  int errors = 0;
  exp_t sb[$];

  logic [4:0] m_ien = '0;
  logic m_fc = 0, m_frz = 1, m_rt = 0, m_bsw = 0, m_tog = 0;
  logic [7:0] m_cnt = '0;

  always #(CLK_PERIOD/2) clk = ~clk;

  pipe_ctl u_pipe_ctl (
    .clk(clk), .rst_n(rst_n), .pipe_dir(pipe_dir), .cfg_ok(cfg_ok),
    .in_limit(in_limit), .ien_set(ien_set), .ien_clr(ien_clr),
    .frz_set(frz_set), .frz_clr(frz_clr), .fifo_clr(fifo_clr),
    .rtog_set(rtog_set), .ev_bank_free(ev_bank_free),
    .ev_in_stored(ev_in_stored), .ev_stall(ev_stall), .ev_err(ev_err),
    .ev_in_done(ev_in_done), .ev_xfer_ok(ev_xfer_ok),
    .ev_pipe_rst(ev_pipe_rst), .ev_pipe_en(ev_pipe_en),
    .ien(ien), .fifo_con(fifo_con), .freeze(freeze), .rtog(rtog),
    .tog_rst(tog_rst), .bank_sw(bank_sw), .data_tog(data_tog)
  );

  task automatic chk1(string tag, string what, logic [4:0] act, logic [4:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s actual=%b expected=%b", tag, what, act, exp);
    end
  endtask

  // Monitor: pops expected items shortly after each rising edge.
  initial begin
    forever begin
      @(posedge clk);
      #2;
      if (sb.size() > 0) begin
        exp_t e;
        e = sb.pop_front();
        chk1(e.tag, "ien", ien, e.ien);
        chk1(e.tag, "fifo_con", {4'b0, fifo_con}, {4'b0, e.fc});
        chk1(e.tag, "freeze", {4'b0, freeze}, {4'b0, e.frz});
        chk1(e.tag, "rtog", {4'b0, rtog}, {4'b0, e.rt});
        chk1(e.tag, "tog_rst", {4'b0, tog_rst}, {4'b0, e.rt});
        chk1(e.tag, "bank_sw", {4'b0, bank_sw}, {4'b0, e.bsw});
        chk1(e.tag, "data_tog", {4'b0, data_tog}, {4'b0, e.tog});
      end
    end
  end

  // Driver: advance the requirement model, queue the prediction, run one cycle.
  task automatic cyc(string tag);
    logic hw_fc, hw_frz, cnt_en, frz_n;
    exp_t e;
    hw_fc  = (pipe_dir == 2'b01) ? ev_in_stored : ev_bank_free;
    cnt_en = ev_in_done & ~m_frz;
    hw_frz = ~cfg_ok | ev_stall | ev_err | ev_pipe_rst | ev_pipe_en
             | (cnt_en & (m_cnt == in_limit));
    frz_n  = hw_frz | frz_set | (m_frz & ~frz_clr);
    if (ev_pipe_rst || (frz_clr && !frz_n)) m_cnt = '0;
    else if (cnt_en) m_cnt = m_cnt + 8'd1;
    m_bsw = fifo_clr & m_fc & ~hw_fc;
    m_fc  = hw_fc | (m_fc & ~fifo_clr);
    m_frz = frz_n;
    m_ien = ien_set | (m_ien & ~ien_clr);
    if (m_rt) m_tog = 1'b0;
    else if (ev_xfer_ok) m_tog = ~m_tog;
    m_rt = rtog_set;
    e.ien = m_ien; e.fc = m_fc; e.frz = m_frz; e.rt = m_rt;
    e.bsw = m_bsw; e.tog = m_tog; e.tag = tag;
    sb.push_back(e);
    @(negedge clk);
    ien_set = '0; ien_clr = '0; frz_set = 0; frz_clr = 0; fifo_clr = 0;
    rtog_set = 0; ev_bank_free = 0; ev_in_stored = 0; ev_stall = 0;
    ev_in_done = 0; ev_xfer_ok = 0; ev_pipe_rst = 0; ev_pipe_en = 0;
  endtask

  initial begin
    #(CLK_PERIOD * 20000);
    errors++;
    $display("FAIL watchdog expired");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    // Reset state: R7 freeze high, R10 DATA0, others low.
    chk1("R7", "reset freeze", {4'b0, freeze}, 5'b00001);
    chk1("R10", "reset data_tog", {4'b0, data_tog}, 5'b0);
    chk1("R1", "reset ien", ien, 5'b0);
    chk1("R5", "reset fifo_con", {4'b0, fifo_con}, 5'b0);

    // R1/R2 interrupt enables
    ien_set = 5'b00101; cyc("R1");
    ien_clr = 5'b00001; cyc("R1");
    ien_set = 5'b00010; ien_clr = 5'b00010; cyc("R1");
    ien_clr = 5'b01000; cyc("R2");
    ien_set = 5'b10000; cyc("R2");
    ien_clr = 5'b11111; cyc("R2");

    // R7 software clear
    frz_clr = 1; cyc("R7");

    // R3 OUT pipe
    pipe_dir = 2'b00;
    ev_in_stored = 1; cyc("R3");
    ev_bank_free = 1; cyc("R3");
    // R5 switch
    fifo_clr = 1; cyc("R5");
    cyc("R5");
    fifo_clr = 1; cyc("R5");
    // R6 collision
    pipe_dir = 2'b10;
    ev_bank_free = 1; cyc("R3");
    ev_bank_free = 1; fifo_clr = 1; cyc("R6");
    fifo_clr = 1; cyc("R5");

    // R4 IN pipe
    pipe_dir = 2'b01;
    ev_bank_free = 1; cyc("R4");
    ev_in_stored = 1; cyc("R4");
    ev_in_stored = 1; fifo_clr = 1; cyc("R6");
    fifo_clr = 1; cyc("R5");

    // R7 hardware freeze causes
    ev_stall = 1; cyc("R7");
    frz_clr = 1; cyc("R7");
    ev_err = 1; cyc("R7");
    ev_err = 0; frz_clr = 1; cyc("R7");
    cfg_ok = 0; cyc("R7");
    cfg_ok = 1; frz_clr = 1; cyc("R7");
    ev_pipe_rst = 1; cyc("R7");
    frz_clr = 1; cyc("R7");
    ev_pipe_en = 1; cyc("R7");
    frz_clr = 1; cyc("R7");
    frz_set = 1; cyc("R7");
    // R11 hardware beats software clear
    ev_stall = 1; frz_clr = 1; cyc("R11");
    cfg_ok = 0; frz_clr = 1; cyc("R11");
    cfg_ok = 1;

    // R8 IN-request limit (limit 2 -> third completion freezes)
    in_limit = 8'd2;
    frz_clr = 1; cyc("R8");
    ev_in_done = 1; cyc("R8");
    ev_in_done = 1; cyc("R8");
    ev_in_done = 1; cyc("R8");
    ev_in_done = 1; cyc("R8");
    frz_clr = 1; cyc("R8");
    ev_in_done = 1; cyc("R8");
    ev_in_done = 1; cyc("R8");
    frz_set = 1; cyc("R8");
    frz_clr = 1; cyc("R8");
    ev_in_done = 1; cyc("R8");
    ev_in_done = 1; cyc("R8");
    ev_in_done = 1; cyc("R8");
    // limit zero: first completion freezes
    in_limit = 8'd0;
    frz_clr = 1; cyc("R8");
    ev_in_done = 1; cyc("R8");

    // R10 toggling, R9 toggle reset
    ev_xfer_ok = 1; cyc("R10");
    ev_xfer_ok = 1; cyc("R10");
    ev_xfer_ok = 1; cyc("R10");
    rtog_set = 1; cyc("R9");
    ev_xfer_ok = 1; cyc("R9");
    cyc("R9");
    cyc("R9");
    for (int k = 0; k < 4; k++) begin
      ev_xfer_ok = 1; cyc("R10");
    end
    cyc("R10");

    @(negedge clk);
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule